// File: doc/BRIEF.md
# Station Bus Arbiter with Acknowledge Retry

This block shares one station bus among several processing modules and a local-ring port. Each requester holds a request line and presents the destination of the packet it wants to send. The arbiter registers its choice, so a grant appears in the cycle after the request. The granted requester drives its packet on the bus during that grant cycle. In the next cycle the arbiter looks for an acknowledge from the expected receiver. If the acknowledge is present, it pulses a done strobe back to the source. If it is missing, the source simply keeps its request raised and is granted again later.

A transfer spans three cycles (request, bus, acknowledge) but occupies the bus for only one of them. Independent transfers can therefore follow each other on consecutive cycles. The ring port takes part in arbitration as the requester with the highest index. It also acknowledges every packet whose station field names another station. Among competing requesters the grant rotates round-robin, starting after the requester granted most recently.

The destination field is `{station, slot}`, with the slot in the low `SLOT_W` bits. With the default parameters this is 2 station bits over 2 slot bits, and the local station is 1.

Top module: `stn_bus_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it, `grant`, `bus_valid` and `xfer_done` are all zero.
- R2: A request raised with no competing requester is granted in the cycle after the clock edge that samples it. `grant` is one-hot or zero at all times.
- R3: In a grant cycle, `bus_valid` is 1, `bus_src` is the index of the granted requester, and `bus_dest` equals that requester's destination field.
- R4: In the cycle after a grant, `xfer_done` shows the source's bit if and only if the expected receiver's `ack_in` bit is high. An acknowledge on any other `ack_in` bit is ignored.
- R5: When the acknowledge is missing, `xfer_done` stays zero. The source, still requesting, is not granted in the acknowledge cycle or in the cycle after it. It is granted again three cycles after its previous grant when uncontended.
- R6: Two requesters raised together are granted on two consecutive cycles, so the bus carries a packet in both.
- R7: With several requesters eligible, the grant goes to the first eligible index after the most recently granted one, wrapping from index `NUM_MODULES` back to 0. After reset, index 0 has first priority.
- R8: A destination whose station field (bits `[DEST_W-1:SLOT_W]`) differs from `LOCAL_STATION` is acknowledged only by `ack_in[NUM_MODULES]` (the ring port). An on-station destination is acknowledged only by `ack_in[slot]`.
- R9: The ring port is requester index `NUM_MODULES`. It is granted and completes transfers like any module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 5 | Request per requester; bit 4 is the ring port |
| req_dest | input | 20 | Destination field per requester, 4 bits each, requester i at bits [4i+3:4i] |
| ack_in | input | 5 | Acknowledge per receiver; bit 4 is the ring port |
| grant | output | 5 | One-hot grant, valid in the bus cycle |
| bus_valid | output | 1 | A packet is on the bus this cycle |
| bus_src | output | 3 | Index of the granted requester |
| bus_dest | output | 4 | Destination field of the packet on the bus |
| xfer_done | output | 5 | One-hot pulse to the source whose packet was acknowledged |

## Verification
The hardest situation to reach from the ports is a retry that happens while other traffic overlaps it. In that case a failed source sits in its acknowledge window while other requesters keep the bus busy. The directed tests get there by first withholding the acknowledge, or answering from the wrong receiver. The retry is then timed to the exact cycle. Next, all five requesters are raised together just after a known grant, so the rotation order, the exclusion of the previous grantee and the per-cycle done strobes are all checked in one overlapping stream.

// File: rtl/sba_pkg.sv
// Package: shared helpers for the station bus arbiter.
// Assumes: indices are small non-negative integers.
package sba_pkg;

    // Advance an index by one, wrapping at n.
    function automatic int wrap_inc(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/sba_rr_picker.sv
// Module: sba_rr_picker
// Picks the first eligible requester after the last one granted, wrapping
// around. This is pure combinational logic.
// Assumes: last < N and IDX_W is wide enough to hold N-1.
module sba_rr_picker #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     elig,
    input  logic [IDX_W-1:0] last,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    import sba_pkg::*;

    logic [IDX_W-1:0] idx;

    // Scan from last+1 around the ring and keep the first hit.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        idx  = last;
        for (int i = 0; i < N; i++) begin
            idx = IDX_W'(wrap_inc(int'(idx), N));
            if (!any && elig[idx]) begin
                any  = 1'b1;
                pick = idx;
            end
        end
    end
endmodule

// File: rtl/sba_ack_tracker.sv
// Module: sba_ack_tracker
// Records the transfer that is on the bus. In the following cycle it checks
// the acknowledge from the expected receiver: the slot for on-station
// destinations, the ring port for all others.
// Assumes: the destination field is {station, slot} with the slot in the low bits.
module sba_ack_tracker #(
    parameter int NREQ          = 5,
    parameter int IDX_W         = 3,
    parameter int SLOT_W        = 2,
    parameter int STATION_W     = 2,
    parameter int LOCAL_STATION = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    input  logic [IDX_W-1:0]            bus_src,
    input  logic [STATION_W+SLOT_W-1:0] bus_dest,
    input  logic [NREQ-1:0]             ack_in,
    output logic [NREQ-1:0]             busy,
    output logic [NREQ-1:0]             done
);
    localparam int DEST_W   = STATION_W + SLOT_W;
    localparam int RING_IDX = NREQ - 1;

    logic             ap_valid;
    logic [IDX_W-1:0] ap_src;
    logic [IDX_W-1:0] ap_tgt;
    logic [IDX_W-1:0] tgt_now;
    logic             ack_seen;

    // Work out which receiver must answer for the packet now on the bus.
    always_comb begin
        if (bus_dest[DEST_W-1:SLOT_W] != STATION_W'(LOCAL_STATION))
            tgt_now = IDX_W'(RING_IDX);
        else
            tgt_now = IDX_W'(bus_dest[SLOT_W-1:0]);
    end

    // Hold the source and receiver through the acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_valid <= 1'b0;
            ap_src   <= '0;
            ap_tgt   <= '0;
        end else begin
            ap_valid <= bus_valid;
            ap_src   <= bus_src;
            ap_tgt   <= tgt_now;
        end
    end

    // Read the expected receiver's acknowledge bit.
    always_comb ack_seen = ap_valid && ack_in[ap_tgt];

    // Per-requester busy mask and done strobe.
    for (genvar g = 0; g < NREQ; g++) begin : g_req
        assign busy[g] = ap_valid && (ap_src == IDX_W'(g));
        assign done[g] = ack_seen && (ap_src == IDX_W'(g));
    end
endmodule

// File: rtl/stn_bus_arbiter.sv
// Module: stn_bus_arbiter
// Station bus arbiter. NUM_MODULES processing modules plus one ring port
// (index NUM_MODULES) compete for the bus, and the grant is registered.
// A source that is on the bus or waiting for its acknowledge is not
// eligible. A missing acknowledge leaves the request raised, which gives
// an automatic retry.
// Assumes: NUM_MODULES >= 2, and a source holds its request and destination
// until it sees its done strobe.
module stn_bus_arbiter #(
    parameter int NUM_MODULES   = 4,
    parameter int STATION_W     = 2,
    parameter int LOCAL_STATION = 1,
    localparam int NREQ   = NUM_MODULES + 1,
    localparam int IDX_W  = $clog2(NREQ),
    localparam int SLOT_W = $clog2(NUM_MODULES),
    localparam int DEST_W = STATION_W + SLOT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req,
    input  logic [NREQ*DEST_W-1:0] req_dest,
    input  logic [NREQ-1:0]        ack_in,
    output logic [NREQ-1:0]        grant,
    output logic                   bus_valid,
    output logic [IDX_W-1:0]       bus_src,
    output logic [DEST_W-1:0]      bus_dest,
    output logic [NREQ-1:0]        xfer_done
);
    logic             gnt_v_q;
    logic [IDX_W-1:0] gnt_idx_q;
    logic [IDX_W-1:0] last_q;
    logic [NREQ-1:0]  ack_busy;
    logic [NREQ-1:0]  elig;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    // Exclude sources that are on the bus or in their acknowledge window.
    always_comb elig = req & ~grant & ~ack_busy;

    sba_rr_picker #(.N(NREQ), .IDX_W(IDX_W)) u_pick (
        .elig (elig),
        .last (last_q),
        .any  (pick_any),
        .pick (pick_idx)
    );

    // Register the grant decision and the round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_v_q   <= 1'b0;
            gnt_idx_q <= '0;
            last_q    <= IDX_W'(NREQ - 1);
        end else begin
            gnt_v_q <= pick_any;
            if (pick_any) begin
                gnt_idx_q <= pick_idx;
                last_q    <= pick_idx;
            end
        end
    end

    // Decode the registered index into the one-hot grant.
    for (genvar g = 0; g < NREQ; g++) begin : g_gnt
        assign grant[g] = gnt_v_q && (gnt_idx_q == IDX_W'(g));
    end

    // Drive the bus view of the granted packet.
    always_comb begin
        bus_valid = gnt_v_q;
        bus_src   = gnt_idx_q;
        bus_dest  = req_dest[int'(gnt_idx_q)*DEST_W +: DEST_W];
    end

    sba_ack_tracker #(
        .NREQ(NREQ), .IDX_W(IDX_W), .SLOT_W(SLOT_W),
        .STATION_W(STATION_W), .LOCAL_STATION(LOCAL_STATION)
    ) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_src   (bus_src),
        .bus_dest  (bus_dest),
        .ack_in    (ack_in),
        .busy      (ack_busy),
        .done      (xfer_done)
    );
endmodule

// File: rtl/sba_checker.sv
// Module: sba_checker
// Property checks for stn_bus_arbiter, attached to it with bind.
// Assumes: the same parameters as the arbiter it watches.
module sba_checker #(
    parameter int NREQ          = 5,
    parameter int IDX_W         = 3,
    parameter int SLOT_W        = 2,
    parameter int DEST_W        = 4,
    parameter int LOCAL_STATION = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   req,
    input logic [NREQ-1:0]   ack_in,
    input logic [NREQ-1:0]   grant,
    input logic              bus_valid,
    input logic [IDX_W-1:0]  bus_src,
    input logic [DEST_W-1:0] bus_dest,
    input logic [NREQ-1:0]   xfer_done
);
    // R2: at most one grant at a time
    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: a grant only follows a sampled request
    a_r2_grant_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (($past(req) & grant) == grant));

    // R3: the bus source matches the granted bit
    a_r3_src_granted: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> grant[bus_src]);

    // R4: done goes only to the source granted one cycle earlier
    a_r4_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done != '0) |-> ($past(grant) == xfer_done));

    // R5: no re-grant in the cycle after a grant
    a_r5_no_back_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> ((grant & $past(grant)) == '0));

    // R5: no re-grant during the acknowledge window
    a_r5_no_regrant_two: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & $past(grant, 2)) == '0);

    // R8: an off-station packet completes only with the ring port's acknowledge
    a_r8_ring_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((xfer_done != '0) && ($past(bus_dest[DEST_W-1:SLOT_W]) != (DEST_W-SLOT_W)'(LOCAL_STATION)))
        |-> ack_in[NREQ-1]);
endmodule

bind stn_bus_arbiter sba_checker #(
    .NREQ(NREQ), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .DEST_W(DEST_W),
    .LOCAL_STATION(LOCAL_STATION)
) u_sba_checker (
    .clk(clk), .rst_n(rst_n), .req(req), .ack_in(ack_in), .grant(grant),
    .bus_valid(bus_valid), .bus_src(bus_src), .bus_dest(bus_dest),
    .xfer_done(xfer_done)
);

// File: tb/stn_bus_arbiter_bench.sv
`timescale 1ns/1ps
// Directed bench for stn_bus_arbiter. Inputs change and outputs are sampled
// on the falling edge.
module stn_bus_arbiter_bench;
    localparam int NREQ = 5;
    localparam int DW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req = '0;
    logic [NREQ*DW-1:0] req_dest = '0;
    logic [NREQ-1:0] ack_in = '0;
    logic [NREQ-1:0] grant;
    logic            bus_valid;
    logic [2:0]      bus_src;
    logic [DW-1:0]   bus_dest;
    logic [NREQ-1:0] xfer_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stn_bus_arbiter u_stn_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .req_dest(req_dest),
        .ack_in(ack_in), .grant(grant), .bus_valid(bus_valid),
        .bus_src(bus_src), .bus_dest(bus_dest), .xfer_done(xfer_done)
    );

    // Count one check and report a mismatch.
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Destination field {station, slot}.
    function automatic logic [DW-1:0] dst(input int stn, input int slot);
        return DW'((stn << 2) | slot);
    endfunction

    // Reset values.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 grant in reset", int'(grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grant after reset", int'(grant), 0);
        check("R1 bus_valid", int'(bus_valid), 0);
        check("R1 xfer_done", int'(xfer_done), 0);
    endtask

    // One uncontended transfer, acknowledged by the right receiver.
    task automatic t_single(input int src, input logic [DW-1:0] d, input int acker, input string tag);
        req_dest[src*DW +: DW] = d;
        req[src] = 1'b1;
        @(negedge clk);
        check({tag, " R2 grant"}, int'(grant), 1 << src);
        check({tag, " R3 bus_valid"}, int'(bus_valid), 1);
        check({tag, " R3 bus_src"}, int'(bus_src), src);
        check({tag, " R3 bus_dest"}, int'(bus_dest), int'(d));
        @(negedge clk);
        ack_in[acker] = 1'b1;
        #1;
        check({tag, " R4 done"}, int'(xfer_done), 1 << src);
        req[src] = 1'b0;
        ack_in = '0;
        @(negedge clk);
        check({tag, " R4 idle after"}, int'(grant), 0);
    endtask

    // A wrong acknowledge is ignored; the retry comes three cycles after the grant.
    task automatic t_retry();
        req_dest[1*DW +: DW] = dst(1, 3);
        req[1] = 1'b1;
        @(negedge clk);
        check("R5 first grant", int'(grant), 2);
        @(negedge clk);
        ack_in[0] = 1'b1;
        #1;
        check("R4 wrong ack ignored", int'(xfer_done), 0);
        ack_in = '0;
        @(negedge clk);
        check("R5 no regrant yet", int'(grant), 0);
        @(negedge clk);
        check("R5 retry grant", int'(grant), 2);
        @(negedge clk);
        ack_in[3] = 1'b1;
        #1;
        check("R5 retry done", int'(xfer_done), 2);
        req[1] = 1'b0;
        ack_in = '0;
    endtask

    // Two independent requesters use the bus on consecutive cycles.
    task automatic t_back_to_back();
        @(negedge clk);
        req_dest[2*DW +: DW] = dst(1, 0);
        req_dest[3*DW +: DW] = dst(1, 1);
        req[2] = 1'b1;
        req[3] = 1'b1;
        @(negedge clk);
        check("R6 first of pair", int'(grant), 4);
        @(negedge clk);
        check("R6 second of pair", int'(grant), 8);
        ack_in[0] = 1'b1;
        #1;
        check("R6 first done", int'(xfer_done), 4);
        req[2] = 1'b0;
        ack_in = '0;
        @(negedge clk);
        ack_in[1] = 1'b1;
        #1;
        check("R6 second done", int'(xfer_done), 8);
        req[3] = 1'b0;
        ack_in = '0;
        @(negedge clk);
    endtask

    // Off-station packet: the slot's acknowledge is ignored, the ring port's counts.
    task automatic t_off_station();
        req_dest[0 +: DW] = dst(3, 2);
        req[0] = 1'b1;
        @(negedge clk);
        check("R8 grant", int'(grant), 1);
        @(negedge clk);
        ack_in[2] = 1'b1;
        #1;
        check("R8 slot ack ignored", int'(xfer_done), 0);
        ack_in = '0;
        @(negedge clk);
        @(negedge clk);
        check("R8 retry grant", int'(grant), 1);
        @(negedge clk);
        ack_in[4] = 1'b1;
        #1;
        check("R8 ring ack done", int'(xfer_done), 1);
        req[0] = 1'b0;
        ack_in = '0;
        @(negedge clk);
    endtask

    // All five requesters raised together after requester 2 was last granted.
    task automatic t_round_robin();
        int order [5] = '{3, 4, 0, 1, 2};
        for (int i = 0; i < NREQ; i++) req_dest[i*DW +: DW] = dst(1, 0);
        req = '1;
        for (int k = 0; k < NREQ; k++) begin
            @(negedge clk);
            check("R7 rotation grant", int'(grant), 1 << order[k]);
            if (k > 0) begin
                ack_in[0] = 1'b1;
                #1;
                check("R7 rotation done", int'(xfer_done), 1 << order[k-1]);
                req[order[k-1]] = 1'b0;
                ack_in = '0;
            end
        end
        @(negedge clk);
        ack_in[0] = 1'b1;
        #1;
        check("R7 last done", int'(xfer_done), 1 << order[4]);
        req = '0;
        ack_in = '0;
        @(negedge clk);
        check("R7 idle", int'(grant), 0);
    endtask

    // Main sequence.
    initial begin
        t_reset();
        @(negedge clk);
        t_single(0, dst(1, 2), 2, "single");
        t_retry();
        t_back_to_back();
        t_off_station();
        t_single(4, dst(1, 1), 1, "R9 ring source");
        t_single(2, dst(1, 3), 3, "pre-rotation");
        t_round_robin();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule